// File: doc/BRIEF.md
# Chip-Select Framed Command Receiver

This block listens on a four-wire serial port as the target device, clock idle low, data captured on the rising serial clock edge. Each frame is enclosed by an active-low chip select. While the select is low, bits arrive most significant first and are packed into bytes. The first byte is a command, the second a payload count, then come the payload bytes, and a trailing CRC-8 byte closes the frame. All three serial lines are brought into the system clock domain through two-flop synchronisers, and their edges are detected there. The system clock must therefore run at least four times faster than the serial clock.

The received frame is held internally until the select line rises. At that point the bit alignment, the declared count, the byte total and the CRC are all checked together. The block then gives a single-cycle pulse on either `frame_valid` or `frame_error`. A valid frame copies its command, count and payload to held outputs. A rejected frame leaves those outputs untouched, so a partial or damaged frame never reaches the consumer. A new falling edge of the select line discards any earlier state and starts over.

Top module: `spi_frame_rx`

## Requirements
- R1: After reset, `frame_valid` and `frame_error` are low and `frame_cmd`, `frame_len` and `frame_payload` are all zero.
- R2: Bits are sampled on rising serial clock edges while the select is low and are assembled MSB first. Byte 0 is the command and byte 1 is the payload count. Payload byte i appears on `frame_payload[8*i+7:8*i]` after a valid frame.
- R3: The final byte must equal a CRC-8 (polynomial 0x07, initial value 0x00, no reflection, no final XOR) taken over command, count and payload bytes. On a mismatch the receiver pulses `frame_error`.
- R4: If the number of serial clock rising edges seen while the select is low is not a multiple of 8, the receiver pulses `frame_error`.
- R5: A payload count above MAX_PAYLOAD gives `frame_error`, even when the byte total and the CRC agree. Payload bytes past MAX_PAYLOAD are counted but not stored.
- R6: A byte total that differs from the payload count plus 3 gives `frame_error`. This covers a select pulse with no clocks at all.
- R7: A result pulse appears only after the select line rises, never while it is low. The pulse lasts exactly one cycle, and `frame_valid` and `frame_error` are never high together.
- R8: A falling select edge restarts reception, so a frame that follows a broken one is decoded cleanly.
- R9: `frame_cmd`, `frame_len` and `frame_payload` change only in the cycle that `frame_valid` is high. A rejected frame leaves the earlier values in place.
- R10: A frame with a payload count of 0 (three bytes in total) is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_sclk | input | 1 | Serial clock from the controller, idle low |
| spi_cs_n | input | 1 | Active-low chip select that encloses a frame |
| spi_mosi | input | 1 | Serial data from the controller |
| frame_valid | output | 1 | One-cycle pulse: the frame passed every check |
| frame_error | output | 1 | One-cycle pulse: the frame was rejected |
| frame_cmd | output | 8 | Command byte of the last valid frame |
| frame_len | output | 8 | Payload count of the last valid frame |
| frame_payload | output | 8*MAX_PAYLOAD | Payload bytes of the last valid frame, byte 0 lowest |

## Verification
The bench builds the receiver with MAX_PAYLOAD set to 4 instead of 16. With that setting a completely full frame, a count one above the limit and a payload byte that spills past the storage all fit in frames of seven or eight bytes. The serial clock runs at one eighth of the system clock, twice the required minimum ratio, so every edge passes through the synchronisers cleanly. Each case pairs a frame with its predicted pulse and output values. For rejected frames, the prediction is the previous valid frame's fields, which checks that the outputs hold.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  // one serial step of a non-reflected CRC-8
  function automatic byte_t crc8_step(input byte_t crc, input logic bit_in,
                                      input byte_t poly);
    logic fb;
    fb = crc[BYTE_W-1] ^ bit_in;
    return {crc[BYTE_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction

endpackage

// File: rtl/spi_frame_sync.sv
module spi_frame_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic cs_n_in,
  input  logic mosi_in,
  output logic rst_n_sync,
  output logic sclk_rise,
  output logic cs_fall,
  output logic cs_rise,
  output logic mosi_s
);

  localparam int unsigned LINES = 3;           // {mosi, cs_n, sclk}
  localparam logic [LINES-1:0] IDLE = 3'b010;

  logic [STAGES-1:0]  rst_chain_q;
  logic [LINES-1:0]   chain_q [STAGES];
  logic [LINES-1:0]   prev_q;
  logic [LINES-1:0]   line_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain_q <= '0;
    else        rst_chain_q <= {rst_chain_q[STAGES-2:0], 1'b1};
  end
  assign rst_n_sync = rst_chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= IDLE;
      prev_q <= IDLE;
    end else begin
      chain_q[0] <= {mosi_in, cs_n_in, sclk_in};
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign line_s    = chain_q[STAGES-1];
  assign sclk_rise = line_s[0] & ~prev_q[0];
  assign cs_fall   = ~line_s[1] & prev_q[1];
  assign cs_rise   = line_s[1] & ~prev_q[1];
  assign mosi_s    = line_s[2];

endmodule

// File: rtl/spi_frame_crc8.sv
module spi_frame_crc8
  import spi_frame_pkg::*;
#(
  parameter byte_t POLY = 8'h07
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  en,
  input  logic  bit_in,
  output logic  residue_zero
);

  byte_t crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = '0;
    else if (en) crc_d = crc8_step(crc_q, bit_in, POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  // message followed by its own CRC leaves a zero remainder
  assign residue_zero = (crc_q == '0);

endmodule

// File: rtl/spi_frame_collect.sv
module spi_frame_collect
  import spi_frame_pkg::*;
#(
  parameter int unsigned MAX_PAYLOAD = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cs_fall,
  input  logic                          cs_rise,
  input  logic                          sclk_rise,
  input  logic                          mosi,
  input  logic                          crc_ok,
  output logic                          bit_take,
  output logic                          close_ok,
  output logic                          close_bad,
  output byte_t                         stage_cmd,
  output byte_t                         stage_len,
  output logic [BYTE_W*MAX_PAYLOAD-1:0] stage_pay
);

  localparam int unsigned CNT_W = 8;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W:0]   OVERHEAD = 9'd3;

  logic             active_q, active_d;
  logic [2:0]       bit_q, bit_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [6:0]       shift_q, shift_d;
  byte_t            cmd_q, cmd_d, len_q, len_d;
  byte_t            pay_q [MAX_PAYLOAD];
  byte_t            pay_d [MAX_PAYLOAD];
  byte_t            byte_in;
  logic             len_bad, count_bad, align_bad, any_bad;

  assign bit_take = active_q & sclk_rise & ~cs_fall & ~cs_rise;
  assign byte_in  = {shift_q, mosi};

  always_comb begin
    active_d = active_q;
    bit_d    = bit_q;
    cnt_d    = cnt_q;
    shift_d  = shift_q;
    cmd_d    = cmd_q;
    len_d    = len_q;
    for (int i = 0; i < MAX_PAYLOAD; i++) pay_d[i] = pay_q[i];
    if (cs_fall) begin
      active_d = 1'b1;
      bit_d    = '0;
      cnt_d    = '0;
      shift_d  = '0;
      cmd_d    = '0;
      len_d    = '0;
    end else if (cs_rise) begin
      active_d = 1'b0;
    end else if (bit_take) begin
      bit_d   = bit_q + 3'd1;
      shift_d = byte_in[6:0];
      if (bit_q == 3'd7) begin
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        if (cnt_q == 8'd0) cmd_d = byte_in;
        if (cnt_q == 8'd1) len_d = byte_in;
        for (int i = 0; i < MAX_PAYLOAD; i++)
          if (cnt_q == CNT_W'(i + 2)) pay_d[i] = byte_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      bit_q    <= '0;
      cnt_q    <= '0;
      shift_q  <= '0;
      cmd_q    <= '0;
      len_q    <= '0;
      for (int i = 0; i < MAX_PAYLOAD; i++) pay_q[i] <= '0;
    end else begin
      active_q <= active_d;
      bit_q    <= bit_d;
      cnt_q    <= cnt_d;
      shift_q  <= shift_d;
      cmd_q    <= cmd_d;
      len_q    <= len_d;
      for (int i = 0; i < MAX_PAYLOAD; i++) pay_q[i] <= pay_d[i];
    end
  end

  assign len_bad   = len_q > CNT_W'(MAX_PAYLOAD);
  assign count_bad = {1'b0, cnt_q} != ({1'b0, len_q} + OVERHEAD);
  assign align_bad = bit_q != 3'd0;
  assign any_bad   = len_bad | count_bad | align_bad | ~crc_ok;
  assign close_ok  = cs_rise & active_q & ~any_bad;
  assign close_bad = cs_rise & active_q & any_bad;

  assign stage_cmd = cmd_q;
  assign stage_len = len_q;
  for (genvar g = 0; g < MAX_PAYLOAD; g++) begin : g_flat
    assign stage_pay[BYTE_W*g +: BYTE_W] = pay_q[g];
  end

  // R6: byte total never decreases within an open frame
  a_r6_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !cs_fall) |=> (cnt_q >= $past(cnt_q)));

  // R4: a misaligned close is never accepted
  a_r4_aligned_accept: assert property (@(posedge clk) disable iff (!rst_n)
    close_ok |-> (bit_q == 3'd0));

endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_frame_pkg::*;
#(
  parameter int unsigned MAX_PAYLOAD = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  CRC_POLY    = 8'h07
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     spi_sclk,
  input  logic                     spi_cs_n,
  input  logic                     spi_mosi,
  output logic                     frame_valid,
  output logic                     frame_error,
  output logic [7:0]               frame_cmd,
  output logic [7:0]               frame_len,
  output logic [8*MAX_PAYLOAD-1:0] frame_payload
);

  localparam int unsigned PAY_W = BYTE_W * MAX_PAYLOAD;

  logic rst_ns, sclk_rise, cs_fall, cs_rise, mosi_s;
  logic bit_take, crc_ok, close_ok, close_bad;
  byte_t stage_cmd, stage_len;
  logic [PAY_W-1:0] stage_pay;

  logic valid_q, valid_d, error_q, error_d;
  byte_t cmd_q, cmd_d, len_q, len_d;
  logic [PAY_W-1:0] pay_q, pay_d;

  spi_frame_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .sclk_in(spi_sclk), .cs_n_in(spi_cs_n),
    .mosi_in(spi_mosi), .rst_n_sync(rst_ns), .sclk_rise(sclk_rise),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .mosi_s(mosi_s)
  );

  spi_frame_crc8 #(.POLY(CRC_POLY)) crc_i (
    .clk(clk), .rst_n(rst_ns), .clr(cs_fall), .en(bit_take),
    .bit_in(mosi_s), .residue_zero(crc_ok)
  );

  spi_frame_collect #(.MAX_PAYLOAD(MAX_PAYLOAD)) collect_i (
    .clk(clk), .rst_n(rst_ns), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .mosi(mosi_s), .crc_ok(crc_ok),
    .bit_take(bit_take), .close_ok(close_ok), .close_bad(close_bad),
    .stage_cmd(stage_cmd), .stage_len(stage_len), .stage_pay(stage_pay)
  );

  always_comb begin
    valid_d = close_ok;
    error_d = close_bad;
    cmd_d   = cmd_q;
    len_d   = len_q;
    pay_d   = pay_q;
    if (close_ok) begin
      cmd_d = stage_cmd;
      len_d = stage_len;
      pay_d = stage_pay;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      valid_q <= 1'b0;
      error_q <= 1'b0;
      cmd_q   <= '0;
      len_q   <= '0;
      pay_q   <= '0;
    end else begin
      valid_q <= valid_d;
      error_q <= error_d;
      cmd_q   <= cmd_d;
      len_q   <= len_d;
      pay_q   <= pay_d;
    end
  end

  assign frame_valid   = valid_q;
  assign frame_error   = error_q;
  assign frame_cmd     = cmd_q;
  assign frame_len     = len_q;
  assign frame_payload = pay_q;

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_ns)
    !(frame_valid && frame_error));

  a_r7_after_close: assert property (@(posedge clk) disable iff (!rst_ns)
    (frame_valid || frame_error) |-> $past(cs_rise));

  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_ns)
    (frame_valid || frame_error) |=> !(frame_valid || frame_error));

  a_r9_hold_fields: assert property (@(posedge clk) disable iff (!rst_ns)
    !frame_valid |-> ($stable(frame_cmd) && $stable(frame_len) && $stable(frame_payload)));

  a_r5_len_limit: assert property (@(posedge clk) disable iff (!rst_ns)
    frame_valid |-> (frame_len <= 8'(MAX_PAYLOAD)));

endmodule

// File: tb/spi_frame_rx_tb.sv
module spi_frame_rx_tb_top;

  localparam int unsigned MAXP = 4;
  localparam int unsigned HALF = 4;

  typedef struct {
    logic             ok;
    logic [7:0]       cmd;
    logic [7:0]       len;
    logic [8*MAXP-1:0] pay;
    int               nb;
    string            tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic frame_valid, frame_error;
  logic [7:0] frame_cmd, frame_len;
  logic [8*MAXP-1:0] frame_payload;

  int checks = 0, errors = 0, cycles = 0;
  exp_t q[$];
  logic [7:0] tx [0:31];
  logic [7:0] last_cmd = 8'h00, last_len = 8'h00;
  logic [8*MAXP-1:0] last_pay = '0;

  always #10 clk = ~clk;

  spi_frame_rx #(.MAX_PAYLOAD(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .frame_valid(frame_valid), .frame_error(frame_error), .frame_cmd(frame_cmd),
    .frame_len(frame_len), .frame_payload(frame_payload)
  );

  task automatic chk(input logic cond, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // monitor: pops predictions as pulses appear
  always @(negedge clk) begin
    if (rst_n && (frame_valid || frame_error)) begin
      chk(cs_n, "R7 pulse while select low", {63'b0, cs_n}, 64'd1);
      chk(!(frame_valid && frame_error), "R7 both pulses", {62'b0, frame_valid, frame_error}, 64'd0);
      if (q.size() == 0) begin
        chk(1'b0, "R7 unexpected pulse", {63'b0, frame_valid}, 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(frame_valid == e.ok, e.tag, {63'b0, frame_valid}, {63'b0, e.ok});
        chk(frame_cmd == e.cmd, {e.tag, " cmd"}, {56'b0, frame_cmd}, {56'b0, e.cmd});
        chk(frame_len == e.len, {e.tag, " len"}, {56'b0, frame_len}, {56'b0, e.len});
        for (int i = 0; i < e.nb && i < MAXP; i++)
          chk(frame_payload[8*i +: 8] == e.pay[8*i +: 8], {e.tag, " payload"},
              {56'b0, frame_payload[8*i +: 8]}, {56'b0, e.pay[8*i +: 8]});
      end
      @(negedge clk);
      chk(!(frame_valid || frame_error), "R7 pulse width", {62'b0, frame_valid, frame_error}, 64'd0);
    end
  end

  function automatic logic [7:0] crc_of(input int n);
    logic [7:0] c = 8'h00;
    for (int b = 0; b < n; b++)
      for (int k = 7; k >= 0; k--) begin
        logic fb = c[7] ^ tx[b][k];
        c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
    return c;
  endfunction

  task automatic build(input logic [7:0] cmd, input logic [7:0] len, input int npay,
                       input logic [7:0] corrupt, input logic [7:0] seed);
    tx[0] = cmd;
    tx[1] = len;
    for (int i = 0; i < npay; i++) tx[2+i] = seed + 8'(i * 8'h11);
    tx[2+npay] = crc_of(2 + npay) ^ corrupt;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int nbytes, input int extra);
    cs_n = 1'b0;
    wait_clk(6);
    for (int b = 0; b < nbytes; b++)
      for (int k = 7; k >= 0; k--) begin
        mosi = tx[b][k]; wait_clk(HALF);
        sclk = 1'b1;     wait_clk(HALF);
        sclk = 1'b0;
      end
    for (int e = 0; e < extra; e++) begin
      mosi = 1'b1; wait_clk(HALF);
      sclk = 1'b1; wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(6);
    cs_n = 1'b1;
    wait_clk(30);
  endtask

  task automatic push_ok(input string tag);
    exp_t e;
    e.ok = 1'b1; e.cmd = tx[0]; e.len = tx[1]; e.nb = int'(tx[1]); e.tag = tag;
    e.pay = '0;
    for (int i = 0; i < MAXP && i < int'(tx[1]); i++) e.pay[8*i +: 8] = tx[2+i];
    q.push_back(e);
    last_cmd = e.cmd; last_len = e.len; last_pay = e.pay;
  endtask

  task automatic push_err(input string tag);
    exp_t e;
    e.ok = 1'b0; e.cmd = last_cmd; e.len = last_len; e.pay = last_pay;
    e.nb = int'(last_len); e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    chk(!frame_valid && !frame_error, "R1 pulses idle", {62'b0, frame_valid, frame_error}, 64'd0);
    chk(frame_cmd == 8'h00 && frame_len == 8'h00, "R1 fields zero", {48'b0, frame_cmd, frame_len}, 64'd0);
    chk(frame_payload == '0, "R1 payload zero", 64'(frame_payload), 64'd0);

    build(8'hA5, 8'd2, 2, 8'h00, 8'h3C); push_ok("R2 R3 good two-byte frame");  send(5, 0);
    build(8'h5A, 8'd0, 0, 8'h00, 8'h00); push_ok("R10 zero-length frame");     send(3, 0);
    build(8'hC3, 8'd4, 4, 8'h00, 8'h81); push_ok("R2 full payload frame");      send(7, 0);
    build(8'h11, 8'd1, 1, 8'h01, 8'h77); push_err("R3 R9 bad CRC");             send(4, 0);
    build(8'h22, 8'd1, 1, 8'h00, 8'h44); push_err("R4 three stray bits");       send(4, 3);
    build(8'h33, 8'd5, 5, 8'h00, 8'h10); push_err("R5 count above limit");      send(8, 0);
    build(8'h44, 8'd2, 3, 8'h00, 8'h20); push_err("R6 one byte too many");      send(6, 0);
    build(8'h55, 8'd2, 1, 8'h00, 8'h30); push_err("R6 one byte short");         send(4, 0);
    push_err("R6 select without clocks");                                       send(0, 0);
    build(8'h66, 8'd3, 3, 8'h00, 8'h50); push_err("R4 broken partial frame");   send(2, 5);
    build(8'h99, 8'd3, 3, 8'h00, 8'h0F); push_ok("R8 clean after broken");      send(6, 0);

    wait_clk(20);
    chk(q.size() == 0, "R7 all frames answered", 64'(q.size()), 64'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule